// File: doc/BRIEF.md
# Scanline Table-Driven DMA Engine

This block is a per-scanline DMA sequencer for eight shared DMA channels. At the start of each frame it prepares every enabled channel from a table held in memory. On each line strobe it sends a short burst of bytes from memory to the B-bus for each channel that is due, then walks each channel's table forward. Each table entry holds a line count. When bit 7 of the count is set, the channel transfers on every line of the entry. When it is clear, the channel transfers only on the first line. A count of zero ends the channel for the rest of the frame. In indirect mode the table also holds a 16-bit pointer to the burst data.

Frame-start and line strobes come from outside. Memory is read through a synchronous byte port with a read latency of one cycle. B-bus writes leave on a strobed byte port. Whenever this engine initialises or services a channel, it pulses that channel's bit on `blk_cancel`, and the block DMA for that channel then stops.

The sequencer has these states. IDLE waits for a pending strobe. INIT_OVH and RUN_OVH are the 8-cycle overhead phases. INIT_SCAN picks the next enabled channel. RUN_SCAN picks the next active channel for bursts. BURST moves one byte per 8-cycle step. UPD_SCAN picks the next active channel to decrement. RL_TBL, RL_PLO and RL_PHI are the reload reads.

The transitions are as follows:
- IDLE goes to INIT_OVH when an init is pending. Otherwise it goes to RUN_OVH when a line is pending.
- INIT_OVH goes to INIT_SCAN.
- INIT_SCAN goes to RL_TBL when a channel is found, and to IDLE when none is left.
- RUN_OVH goes to RUN_SCAN.
- RUN_SCAN goes to BURST when the chosen channel has its transfer flag set. It stays in RUN_SCAN when the flag is clear, and goes to UPD_SCAN when no channel is left.
- BURST returns to RUN_SCAN after the last byte.
- UPD_SCAN goes to RL_TBL when the low 7 counter bits reach zero. It stays in UPD_SCAN otherwise, and goes to IDLE when no channel is left.
- RL_TBL goes to RL_PLO in indirect mode. Otherwise it returns to its scan state.
- RL_PLO goes to RL_PHI, or returns to its scan state when the high byte is skipped.
- RL_PHI returns to its scan state.

Top module: `scan_dma_engine`

## Requirements
- R1: After reset, `busy`, `mem_rd`, `bb_we` and `blk_cancel` are low, and every channel's complete and do-transfer flags are clear. A line strobe before any init therefore writes nothing to the B-bus.
- R2: An init strobe causes an 8-cycle overhead. Then, for each enabled channel in ascending order, the engine pulses that channel's `blk_cancel` bit, loads its table pointer from `ch_src`, zeroes its line counter and performs the reload.
- R3: The reload reads one table byte at {`ch_sbank`, table pointer} only when the low 7 bits of the line counter are zero. That byte becomes the counter and the pointer increments. A byte of 0 marks the channel complete; any other byte sets its do-transfer flag.
- R4: The burst length for modes 0 to 7 is 1, 2, 2, 4, 4, 4, 2 and 4 bytes. Byte k of a burst goes to `bb_addr` = `ch_dest` + offset. The offsets are:
  - modes 0, 2 and 6: always 0
  - modes 1 and 5: k mod 2
  - modes 3 and 7: (k/2) mod 2
  - mode 4: k mod 4
- R5: Burst bytes are read from {`ch_sbank`, table pointer} in direct mode and from {`ch_ibank`, indirect pointer} in indirect mode. Each read post-increments the pointer it used.
- R6: After all bursts of a line, each active channel (enabled and not complete) decrements its counter and copies the new bit 7 into its do-transfer flag, then performs the reload. An entry whose count has bit 7 clear transfers only on its first line. An entry with bit 7 set transfers on every line.
- R7: In indirect mode the reload also reads the pointer, low byte first, giving pointer = {high, low}. The high byte is read only if the channel is not complete, or some higher-numbered channel is active. When it is skipped, the pointer becomes {low, 0x00}.
- R8: A complete channel causes no burst, no memory read and no `blk_cancel` pulse on later lines of the frame.
- R9: On each line, every active channel gets exactly one `blk_cancel` pulse, and at most one bit of `blk_cancel` is high in any cycle.
- R10: An init or line strobe that arrives while the engine is busy is held pending and serviced after the current sequence. When both are pending, the init runs first. `busy` is high in the cycle after any strobe.
- R11: Within a line, channels are serviced in ascending index order, both for bursts and for counter updates.
- R12: Every table, pointer or burst byte costs an 8-cycle step. `mem_rd` pulses in the first cycle of the step. A burst byte's `bb_we` comes in the last cycle, 7 cycles after its read, and `mem_rd` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_init | input | 1 | Frame-start strobe |
| line_trig | input | 1 | Line strobe |
| ch_en | input | 8 | Per-channel engine enable |
| ch_indirect | input | 8 | Per-channel indirect mode |
| ch_mode | input | 24 | Per-channel burst mode, 3 bits each |
| ch_dest | input | 64 | Per-channel B-bus base offset, 8 bits each |
| ch_src | input | 128 | Per-channel table start address, 16 bits each |
| ch_sbank | input | 64 | Per-channel table bank, 8 bits each |
| ch_ibank | input | 64 | Per-channel indirect data bank, 8 bits each |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 24 | Memory byte address {bank, address} |
| mem_rdata | input | 8 | Read data, valid from the cycle after `mem_rd` |
| bb_we | output | 1 | B-bus write strobe |
| bb_addr | output | 8 | B-bus register offset |
| bb_data | output | 8 | B-bus write data |
| blk_cancel | output | 8 | One-cycle pulse that stops block DMA on a channel |
| busy | output | 1 | Sequence running or strobe pending |

## Verification
The burst path is driven with every mode, which separates the eight length and offset patterns, and with memory bytes that all differ, so a wrong pointer or a missed post-increment shows up in the data. Counter behaviour is tested with a table that mixes a non-repeating entry and a repeating entry. Its per-line write counts (1, 0, 0, 1, 1, 0) separate the decrement, the bit-7 repeat rule, the reload at a zero low field and termination. The indirect path is run twice: once with only the indirect channel enabled and once with a higher channel still active. This tells apart the skipped and the fetched high pointer byte, using the exact list of memory read addresses. A line strobe issued during an init shows whether pending strobes are held.

// File: rtl/scan_dma_pkg.sv
package scan_dma_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_INIT_OVH,
        S_INIT_SCAN,
        S_RUN_OVH,
        S_RUN_SCAN,
        S_BURST,
        S_UPD_SCAN,
        S_RL_TBL,
        S_RL_PLO,
        S_RL_PHI
    } seq_state_e;

    // Bytes per line burst for each transfer mode.
    function automatic logic [2:0] burst_len(input logic [2:0] mode);
        unique case (mode)
            3'd0:                return 3'd1;
            3'd1, 3'd2, 3'd6:    return 3'd2;
            default:             return 3'd4;
        endcase
    endfunction

    // B-bus offset added to the channel base for byte k of a burst.
    function automatic logic [1:0] burst_off(input logic [2:0] mode, input logic [1:0] k);
        unique case (mode)
            3'd1, 3'd5: return {1'b0, k[0]};
            3'd3, 3'd7: return {1'b0, k[1]};
            3'd4:       return k;
            default:    return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/scan_dma_pick.sv
module scan_dma_pick #(
    parameter int NCH = 8,
    localparam int IW = $clog2(NCH),
    localparam int SW = IW + 1
) (
    input  logic [NCH-1:0] mask,
    input  logic [SW-1:0]  from,
    output logic           found,
    output logic [IW-1:0]  pick
);
    // Lowest set index at or above 'from'.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && (SW'(i) >= from)) begin
                found = 1'b1;
                pick  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/scan_dma_tick.sv
module scan_dma_tick #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [TW-1:0] lim,
    output logic [TW-1:0] cnt,
    output logic          last
);
    assign last = en && (cnt == lim - TW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!en || last)  cnt <= '0;
        else                   cnt <= cnt + TW'(1);
    end
endmodule

// File: rtl/scan_dma_engine.sv
module scan_dma_engine
    import scan_dma_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int BW       = 8,
    parameter int AW       = 2 * BW,
    parameter int OVH_CYC  = 8,
    parameter int STEP_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_init,
    input  logic              line_trig,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NCH-1:0]    ch_indirect,
    input  logic [NCH*3-1:0]  ch_mode,
    input  logic [NCH*BW-1:0] ch_dest,
    input  logic [NCH*AW-1:0] ch_src,
    input  logic [NCH*BW-1:0] ch_sbank,
    input  logic [NCH*BW-1:0] ch_ibank,
    output logic              mem_rd,
    output logic [BW+AW-1:0]  mem_addr,
    input  logic [BW-1:0]     mem_rdata,
    output logic              bb_we,
    output logic [BW-1:0]     bb_addr,
    output logic [BW-1:0]     bb_data,
    output logic [NCH-1:0]    blk_cancel,
    output logic              busy
);
    localparam int IW   = $clog2(NCH);
    localparam int SW   = IW + 1;
    localparam int TMAX = (OVH_CYC > STEP_CYC) ? OVH_CYC : STEP_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    // Per-channel configuration views
    logic [2:0]    mode_a [NCH];
    logic [BW-1:0] dest_a [NCH];
    logic [AW-1:0] src_a  [NCH];
    logic [BW-1:0] sbk_a  [NCH];
    logic [BW-1:0] ibk_a  [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_cfg
        assign mode_a[g] = ch_mode [g*3  +: 3];
        assign dest_a[g] = ch_dest [g*BW +: BW];
        assign src_a[g]  = ch_src  [g*AW +: AW];
        assign sbk_a[g]  = ch_sbank[g*BW +: BW];
        assign ibk_a[g]  = ch_ibank[g*BW +: BW];
    end

    // Sequencer and channel state
    seq_state_e    state;
    logic [IW-1:0] idx;
    logic [SW-1:0] from;
    logic [1:0]    bi;
    logic          in_init;
    logic          init_pend, line_pend;
    logic [NCH-1:0] done, xfer;
    logic [AW-1:0] tptr [NCH];
    logic [AW-1:0] iptr [NCH];
    logic [BW-1:0] lcnt [NCH];

    logic [NCH-1:0] active;
    assign active = ch_en & ~done;

    // Channel picker
    logic [NCH-1:0] pmask;
    logic           pick_ok;
    logic [IW-1:0]  pick_id;

    always_comb begin
        pmask = active;
        if (state == S_INIT_SCAN) pmask = ch_en;
    end

    scan_dma_pick #(.NCH(NCH)) u_pick (
        .mask  (pmask),
        .from  (from),
        .found (pick_ok),
        .pick  (pick_id)
    );

    // Step timer
    logic          timed, tlast;
    logic [TW-1:0] tlim, tcnt;

    assign timed = (state == S_INIT_OVH) || (state == S_RUN_OVH) || (state == S_BURST) ||
                   (state == S_RL_TBL)   || (state == S_RL_PLO)  || (state == S_RL_PHI);
    assign tlim  = ((state == S_INIT_OVH) || (state == S_RUN_OVH)) ? TW'(OVH_CYC) : TW'(STEP_CYC);

    scan_dma_tick #(.TW(TW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (timed),
        .lim   (tlim),
        .cnt   (tcnt),
        .last  (tlast)
    );

    // Any active channel above the one being reloaded
    logic above_act;
    always_comb begin
        above_act = 1'b0;
        for (int i = 0; i < NCH; i++)
            if ((i > int'(idx)) && active[i]) above_act = 1'b1;
    end

    logic [BW-1:0] dec;
    logic [2:0]    blen_m1;
    logic [SW-1:0] idx_nxt, pick_nxt;
    seq_state_e    ret_state;

    assign dec       = lcnt[pick_id] - BW'(1);
    assign blen_m1   = burst_len(mode_a[idx]) - 3'd1;
    assign idx_nxt   = SW'(idx) + SW'(1);
    assign pick_nxt  = SW'(pick_id) + SW'(1);
    assign ret_state = in_init ? S_INIT_SCAN : S_UPD_SCAN;

    // State register and channel datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            idx       <= '0;
            from      <= '0;
            bi        <= '0;
            in_init   <= 1'b0;
            init_pend <= 1'b0;
            line_pend <= 1'b0;
            done      <= '0;
            xfer      <= '0;
            for (int i = 0; i < NCH; i++) begin
                tptr[i] <= '0;
                iptr[i] <= '0;
                lcnt[i] <= '0;
            end
        end else begin
            init_pend <= init_pend | frame_init;
            line_pend <= line_pend | line_trig;
            unique case (state)
                S_IDLE: begin
                    if (init_pend) begin
                        state     <= S_INIT_OVH;
                        init_pend <= frame_init;
                    end else if (line_pend) begin
                        state     <= S_RUN_OVH;
                        line_pend <= line_trig;
                    end
                end
                S_INIT_OVH: begin
                    if (tlast) begin
                        state   <= S_INIT_SCAN;
                        from    <= '0;
                        in_init <= 1'b1;
                    end
                end
                S_INIT_SCAN: begin
                    if (pick_ok) begin
                        idx           <= pick_id;
                        tptr[pick_id] <= src_a[pick_id];
                        lcnt[pick_id] <= '0;
                        state         <= S_RL_TBL;
                    end else begin
                        state <= S_IDLE;
                    end
                end
                S_RUN_OVH: begin
                    if (tlast) begin
                        state   <= S_RUN_SCAN;
                        from    <= '0;
                        in_init <= 1'b0;
                    end
                end
                S_RUN_SCAN: begin
                    if (!pick_ok) begin
                        state <= S_UPD_SCAN;
                        from  <= '0;
                    end else if (xfer[pick_id]) begin
                        idx   <= pick_id;
                        bi    <= '0;
                        state <= S_BURST;
                    end else begin
                        from <= pick_nxt;
                    end
                end
                S_BURST: begin
                    if (tlast) begin
                        if (ch_indirect[idx]) iptr[idx] <= iptr[idx] + AW'(1);
                        else                  tptr[idx] <= tptr[idx] + AW'(1);
                        if ({1'b0, bi} == blen_m1) begin
                            state <= S_RUN_SCAN;
                            from  <= idx_nxt;
                        end else begin
                            bi <= bi + 2'd1;
                        end
                    end
                end
                S_UPD_SCAN: begin
                    if (!pick_ok) begin
                        state <= S_IDLE;
                    end else begin
                        idx           <= pick_id;
                        lcnt[pick_id] <= dec;
                        xfer[pick_id] <= dec[BW-1];
                        if (dec[BW-2:0] == '0) state <= S_RL_TBL;
                        else                   from  <= pick_nxt;
                    end
                end
                S_RL_TBL: begin
                    if (tlast) begin
                        lcnt[idx] <= mem_rdata;
                        tptr[idx] <= tptr[idx] + AW'(1);
                        done[idx] <= (mem_rdata == '0);
                        xfer[idx] <= (mem_rdata != '0);
                        if (ch_indirect[idx]) begin
                            state <= S_RL_PLO;
                        end else begin
                            state <= ret_state;
                            from  <= idx_nxt;
                        end
                    end
                end
                S_RL_PLO: begin
                    if (tlast) begin
                        iptr[idx] <= {mem_rdata, {(AW-BW){1'b0}}};
                        tptr[idx] <= tptr[idx] + AW'(1);
                        if (!done[idx] || above_act) begin
                            state <= S_RL_PHI;
                        end else begin
                            state <= ret_state;
                            from  <= idx_nxt;
                        end
                    end
                end
                S_RL_PHI: begin
                    if (tlast) begin
                        iptr[idx] <= {mem_rdata, iptr[idx][AW-1:AW-BW]};
                        tptr[idx] <= tptr[idx] + AW'(1);
                        state     <= ret_state;
                        from      <= idx_nxt;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_rd     = 1'b0;
        mem_addr   = {sbk_a[idx], tptr[idx]};
        bb_we      = 1'b0;
        bb_addr    = dest_a[idx] + BW'(burst_off(mode_a[idx], bi));
        bb_data    = mem_rdata;
        blk_cancel = '0;
        busy       = (state != S_IDLE) || init_pend || line_pend;
        if ((state == S_BURST) && ch_indirect[idx])
            mem_addr = {ibk_a[idx], iptr[idx]};
        if (((state == S_BURST) || (state == S_RL_TBL) || (state == S_RL_PLO) ||
             (state == S_RL_PHI)) && (tcnt == '0))
            mem_rd = 1'b1;
        if ((state == S_BURST) && tlast)
            bb_we = 1'b1;
        if (((state == S_INIT_SCAN) || (state == S_RUN_SCAN)) && pick_ok)
            blk_cancel[pick_id] = 1'b1;
    end

endmodule

// File: rtl/scan_dma_chk.sv
module scan_dma_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           frame_init,
    input logic           line_trig,
    input logic           busy,
    input logic           mem_rd,
    input logic           bb_we,
    input logic [NCH-1:0] blk_cancel
);
    assert_cancel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_cancel));

    assert_rd_spaced_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    assert_wr_not_rd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bb_we |-> !mem_rd);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !bb_we && (blk_cancel == '0)));

    assert_strobe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_init || line_trig) |=> busy);

endmodule

bind scan_dma_engine scan_dma_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_init (frame_init),
    .line_trig  (line_trig),
    .busy       (busy),
    .mem_rd     (mem_rd),
    .bb_we      (bb_we),
    .blk_cancel (blk_cancel)
);

// File: tb/scan_dma_engine_tb.sv
module scan_dma_engine_tb;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_init = 1'b0, line_trig = 1'b0;
    logic [NCH-1:0]    ch_en = '0, ch_indirect = '0;
    logic [NCH*3-1:0]  ch_mode = '0;
    logic [NCH*8-1:0]  ch_dest = '0, ch_sbank = '0, ch_ibank = '0;
    logic [NCH*16-1:0] ch_src = '0;
    logic        mem_rd, bb_we, busy;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00, bb_addr, bb_data;
    logic [NCH-1:0] blk_cancel;

    always #5 clk = ~clk;

    scan_dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .frame_init(frame_init), .line_trig(line_trig),
        .ch_en(ch_en), .ch_indirect(ch_indirect), .ch_mode(ch_mode), .ch_dest(ch_dest),
        .ch_src(ch_src), .ch_sbank(ch_sbank), .ch_ibank(ch_ibank),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .bb_we(bb_we), .bb_addr(bb_addr), .bb_data(bb_data),
        .blk_cancel(blk_cancel), .busy(busy)
    );

    // Memory model: synchronous read, one cycle latency
    logic [7:0] mem [0:2047];
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[10:0]];

    // Monitors
    int n_tests = 0, n_fail = 0;
    int cyc = 0, last_rd = 0, gap0 = 0;
    int wr_n = 0, rd_n = 0;
    logic [7:0]  wr_addr [32];
    logic [7:0]  wr_data [32];
    logic [23:0] rd_addr [32];
    logic [NCH-1:0] cancel_or = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (bb_we) begin
            if (wr_n == 0) gap0 = cyc - last_rd;
            if (wr_n < 32) begin
                wr_addr[wr_n] = bb_addr;
                wr_data[wr_n] = bb_data;
            end
            wr_n++;
        end
        if (mem_rd) begin
            last_rd = cyc;
            if (rd_n < 32) rd_addr[rd_n] = mem_addr;
            rd_n++;
        end
        cancel_or |= blk_cancel;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr_logs();
        wr_n = 0; rd_n = 0; cancel_or = '0; gap0 = 0;
    endtask

    task automatic fill_mem();
        for (int a = 0; a < 2048; a++) mem[a] = pat(a);
    endtask

    task automatic set_ch(input int i, input logic [2:0] m, input logic ind,
                          input logic [7:0] d, input logic [15:0] s,
                          input logic [7:0] sb, input logic [7:0] ib);
        ch_mode[i*3 +: 3]   = m;
        ch_indirect[i]      = ind;
        ch_dest[i*8 +: 8]   = d;
        ch_src[i*16 +: 16]  = s;
        ch_sbank[i*8 +: 8]  = sb;
        ch_ibank[i*8 +: 8]  = ib;
    endtask

    task automatic wait_idle();
        int t = 0;
        @(negedge clk);
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (busy) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: busy stuck actual=1 expected=0");
        end
    endtask

    task automatic pulse_init();
        @(negedge clk) frame_init = 1'b1;
        @(negedge clk) frame_init = 1'b0;
        wait_idle();
    endtask

    task automatic pulse_line();
        @(negedge clk) line_trig = 1'b1;
        @(negedge clk) line_trig = 1'b0;
        wait_idle();
    endtask

    // {mode, length, packed offsets (2 bits per byte, byte 0 lowest)}
    localparam logic [13:0] VEC [8] = '{
        {3'd0, 3'd1, 8'h00},
        {3'd1, 3'd2, 8'h04},
        {3'd2, 3'd2, 8'h00},
        {3'd3, 3'd4, 8'h50},
        {3'd4, 3'd4, 8'hE4},
        {3'd5, 3'd4, 8'h44},
        {3'd6, 3'd2, 8'h00},
        {3'd7, 3'd4, 8'h50}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        fill_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: idle outputs after reset
        chk("R1 busy", busy, 0);
        chk("R1 mem_rd", mem_rd, 0);
        chk("R1 bb_we", bb_we, 0);
        chk("R1 blk_cancel", blk_cancel, 0);

        // R1: do-transfer cleared -> line without init writes nothing; R9 cancel
        ch_en = 8'h01;
        set_ch(0, 3'd0, 1'b0, 8'h18, 16'h0100, 8'h07, 8'h00);
        clr_logs();
        pulse_line();
        chk("R1 no writes before init", wr_n, 0);
        chk("R9 cancel for active ch0", cancel_or, 8'h01);

        // R4 R5 R6 R12 R8: every mode from the vector table
        for (int v = 0; v < 8; v++) begin
            logic [2:0] m;
            logic [2:0] len;
            logic [7:0] offs;
            {m, len, offs} = VEC[v];
            fill_mem();
            mem[16'h100] = 8'h81;
            mem[16'h101 + int'(len)] = 8'h00;
            ch_en = 8'h01;
            set_ch(0, m, 1'b0, 8'h18, 16'h0100, 8'h07, 8'h00);
            clr_logs();
            pulse_init();
            chk("R2 init cancel", cancel_or, 8'h01);
            chk("R3 init reads one table byte", rd_n, 1);
            chk("R3 table address", rd_addr[0], 24'h070100);
            clr_logs();
            pulse_line();
            chk("R4 burst length", wr_n, int'(len));
            for (int k = 0; k < int'(len); k++) begin
                chk("R4 bbus offset", wr_addr[k], 8'h18 + {6'd0, offs[2*k +: 2]});
                chk("R5 burst data", wr_data[k], pat(16'h101 + k));
            end
            chk("R12 read to write gap", gap0, 7);
            clr_logs();
            pulse_line();
            chk("R8 complete: no writes", wr_n, 0);
            chk("R8 complete: no reads", rd_n, 0);
            chk("R8 complete: no cancel", cancel_or, 0);
        end

        // R6 R3: non-repeat entry then repeat entry then terminator
        fill_mem();
        mem[16'h100] = 8'h03; mem[16'h101] = 8'hA1;
        mem[16'h102] = 8'h82; mem[16'h103] = 8'hB2;
        mem[16'h104] = 8'hC3; mem[16'h105] = 8'h00;
        ch_en = 8'h01;
        set_ch(0, 3'd0, 1'b0, 8'h10, 16'h0100, 8'h07, 8'h00);
        pulse_init();
        begin
            int exp_n [6] = '{1, 0, 0, 1, 1, 0};
            logic [7:0] exp_d [6] = '{8'hA1, 8'h00, 8'h00, 8'hB2, 8'hC3, 8'h00};
            for (int l = 0; l < 6; l++) begin
                clr_logs();
                pulse_line();
                chk("R6 writes per line", wr_n, exp_n[l]);
                if (exp_n[l] == 1) chk("R6 line data", wr_data[0], exp_d[l]);
            end
        end

        // R7 R5: indirect, high byte skipped (no higher channel active)
        fill_mem();
        mem[16'h200] = 8'h01; mem[16'h201] = 8'h40; mem[16'h202] = 8'h03;
        mem[16'h203] = 8'h00; mem[16'h204] = 8'h55; mem[16'h205] = 8'h06;
        mem[16'h340] = 8'h9A; mem[16'h341] = 8'h9B;
        ch_en = 8'h02;
        set_ch(1, 3'd1, 1'b1, 8'h22, 16'h0200, 8'h07, 8'h33);
        pulse_init();
        clr_logs();
        pulse_line();
        chk("R5 indirect data 0", wr_data[0], 8'h9A);
        chk("R5 indirect data 1", wr_data[1], 8'h9B);
        chk("R4 mode1 second offset", wr_addr[1], 8'h23);
        chk("R5 indirect bank address", rd_addr[0], 24'h330340);
        chk("R7 skip: read count", rd_n, 4);
        chk("R7 skip: last read is low byte", rd_addr[3], 24'h070204);

        // R7 R11: indirect, high byte fetched because ch2 still active
        mem[16'h300] = 8'h85; mem[16'h301] = 8'hC7;
        ch_en = 8'h06;
        set_ch(2, 3'd0, 1'b0, 8'h30, 16'h0300, 8'h07, 8'h00);
        clr_logs();
        pulse_init();
        chk("R2 init cancel both", cancel_or, 8'h06);
        clr_logs();
        pulse_line();
        chk("R11 write count", wr_n, 3);
        chk("R11 ch1 first", wr_addr[0], 8'h22);
        chk("R11 ch2 last", wr_addr[2], 8'h30);
        chk("R5 ch2 data", wr_data[2], 8'hC7);
        chk("R7 fetch: read count", rd_n, 6);
        chk("R7 fetch: high byte read", rd_addr[5], 24'h070205);
        chk("R9 cancel both active", cancel_or, 8'h06);
        clr_logs();
        pulse_line();
        chk("R8 only ch2 cancelled", cancel_or, 8'h04);
        chk("R6 ch2 repeats", wr_n, 1);

        // R10: line strobe during init is held and serviced afterwards
        fill_mem();
        mem[16'h100] = 8'h81; mem[16'h101] = 8'hD4; mem[16'h102] = 8'h00;
        ch_en = 8'h01;
        set_ch(0, 3'd0, 1'b0, 8'h18, 16'h0100, 8'h07, 8'h00);
        clr_logs();
        @(negedge clk) frame_init = 1'b1;
        @(negedge clk) frame_init = 1'b0;
        repeat (3) @(negedge clk);
        line_trig = 1'b1;
        @(negedge clk) line_trig = 1'b0;
        wait_idle();
        chk("R10 pending line serviced", wr_n, 1);
        chk("R10 pending line data", wr_data[0], 8'hD4);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule